// File: doc/BRIEF.md
# Bank-Select Pointer Register

This block is the 8-bit file-select pointer of a small 8-bit controller core. The register holds an indirect address. Its upper bits also choose the active data-memory bank. The block takes three kinds of operation from the core's decoder:

- a full byte write;
- a bank load that carries a 3-bit literal;
- an increment whose zero result feeds the core's skip decision.

A static mode input sets how the bank bits are placed. In standard layout, the literal goes into the top three bits. In the single-bank compatible layout, the top three bits always read as ones. In the wide layout, the memory is split into two groups of eight banks: the literal goes one position lower, and the top bit picks the group.

The pointer output is the stored value seen through the mode's read mask. The zero flag is a registered one-cycle result of the last increment. The decoder, the register file and program-counter paging are not part of this block.

Top module: `fsel_ptr_unit`

## Requirements
- R1: While reset is held, `ptr_o` reads 0x00 in modes 0, 2 and 3, reads 0xE0 in mode 1, and `inc_zero_o` is 0.
- R2: A byte write (`wr_en`) loads all eight bits of `wr_data` into the pointer, visible on `ptr_o` one clock later.
- R3: In mode 0 (standard), a bank load puts `bank_lit` into pointer bits 7:5 and keeps bits 4:0, in one clock. A bank load never raises `inc_zero_o`.
- R4: In mode 1 (compatible), `ptr_o` bits 7:5 are always 1, whatever is written or bank-loaded. Bits 4:0 follow byte writes.
- R5: In mode 1, incrementing a visible 0xFF raises `inc_zero_o` on the next cycle, and `ptr_o` reads 0xE0.
- R6: In mode 2 (wide), a bank load puts `bank_lit` into bits 6:4 and keeps bit 7 and bits 3:0.
- R7: In mode 2, a byte write sets bit 7 and the bank bits 6:4 together.
- R8: When operations coincide, the byte write wins over the bank load, and the bank load wins over the increment.
- R9: An increment stores the visible value plus one, modulo 256. `inc_zero_o` is 1 for exactly the cycle after an increment whose result is 0x00, and is 0 after any other cycle.
- R10: Mode encoding is 0 standard, 1 compatible, 2 wide. Code 3 behaves as standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Layout mode (0 standard, 1 compatible, 2 wide, 3 as standard) |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| bank_ld | input | 1 | Bank-load strobe |
| bank_lit | input | 3 | Bank literal |
| inc_en | input | 1 | Increment strobe |
| ptr_o | output | 8 | Visible pointer value |
| inc_zero_o | output | 1 | Zero result of the previous cycle's increment |

## Verification
The bench builds the block with its default widths: an 8-bit pointer and a 3-bit bank field. At these widths, the 0xFF-to-zero wrap, the full 3-bit literal range and the exact bit slots used by each layout can all be reached within a few dozen operations. The mode is switched while the stored value is kept. This lets the bench see that the compatible mask acts on the read path only, and that the wide layout keeps the group bit across bank loads.

// File: rtl/fsel_pkg.sv
// Package fsel_pkg
// Shared types for the pointer unit: the layout mode and the operation
// picked in a cycle. Assumes a 2-bit mode code from the core.
package fsel_pkg;

    typedef enum logic [1:0] {
        MODE_STD    = 2'd0,
        MODE_COMPAT = 2'd1,
        MODE_WIDE   = 2'd2,
        MODE_ALT    = 2'd3
    } fsel_mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BANK  = 2'd2,
        OP_INC   = 2'd3
    } fsel_op_e;

endpackage

// File: rtl/fsel_op_arbiter.sv
// Module fsel_op_arbiter
// Picks one operation per cycle from the three strobes: write, then bank
// load, then increment. Assumes strobes are single-cycle and synchronous.
module fsel_op_arbiter
    import fsel_pkg::*;
(
    input  logic     wr_en,
    input  logic     bank_ld,
    input  logic     inc_en,
    output fsel_op_e op_o
);

    // Fixed-priority choice of the cycle's operation.
    always_comb begin
        if (wr_en)
            op_o = OP_WRITE;
        else if (bank_ld)
            op_o = OP_BANK;
        else if (inc_en)
            op_o = OP_INC;
        else
            op_o = OP_NONE;
    end

    // R8: a raised write strobe is never displaced by a lower-priority op.
    always_comb begin
        if (wr_en) begin
            p_write_first_r8: assert (op_o == OP_WRITE);
        end
    end

endmodule

// File: rtl/fsel_bank_merge.sv
// Module fsel_bank_merge
// Forms the pointer value that a bank load leaves behind. The literal is
// placed at the top of the word, or one bit lower in wide mode. Assumes
// DATA_W > BANK_W + 1, so that the wide slot fits below the group bit.
module fsel_bank_merge
    import fsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3
) (
    input  logic [DATA_W-1:0] cur_i,
    input  logic [BANK_W-1:0] lit_i,
    input  fsel_mode_e        mode_i,
    output logic [DATA_W-1:0] merged_o
);

    localparam int STD_LSB  = DATA_W - BANK_W;
    localparam int WIDE_LSB = DATA_W - 1 - BANK_W;

    logic [DATA_W-1:0] std_val;
    logic [DATA_W-1:0] wide_val;

    // Literal in the top bits; every other bit is kept.
    always_comb begin
        std_val = cur_i;
        std_val[STD_LSB +: BANK_W] = lit_i;
    end

    // Literal just under the group bit; the group bit and low bits are kept.
    always_comb begin
        wide_val = cur_i;
        wide_val[WIDE_LSB +: BANK_W] = lit_i;
    end

    // Choose the slot by layout. The compatible and spare codes use the
    // standard slot.
    always_comb begin
        merged_o = (mode_i == MODE_WIDE) ? wide_val : std_val;
    end

endmodule

// File: rtl/fsel_view_mask.sv
// Module fsel_view_mask
// Read-path mask. In compatible mode the top BANK_W bits read as ones;
// the stored register is not changed. Assumes BANK_W < DATA_W.
module fsel_view_mask
    import fsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3
) (
    input  logic [DATA_W-1:0] stored_i,
    input  fsel_mode_e        mode_i,
    output logic [DATA_W-1:0] view_o
);

    localparam int STD_LSB = DATA_W - BANK_W;

    logic force_hi;

    // Compatible layout pins the bank bits.
    always_comb force_hi = (mode_i == MODE_COMPAT);

    // Low bits pass through; bank bits are forced to one when pinned.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= STD_LSB) begin : g_bank
            assign view_o[b] = stored_i[b] | force_hi;
        end else begin : g_low
            assign view_o[b] = stored_i[b];
        end
    end

endmodule

// File: rtl/fsel_incr.sv
// Module fsel_incr
// Adds one to the visible pointer and reports whether the full-width
// result wrapped to zero. The zero test is taken before any read mask.
module fsel_incr #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              zero_o
);

    // Add one, dropping the carry out of the top bit.
    always_comb sum_o = val_i + DATA_W'(1);

    // Zero test on the unmasked sum.
    always_comb zero_o = (sum_o == '0);

    // R9: a zero sum only comes from an all-ones operand.
    always_comb begin
        if (zero_o) begin
            p_zero_from_ones_r9: assert (&val_i);
        end
    end

endmodule

// File: rtl/fsel_ptr_unit.sv
// Module fsel_ptr_unit
// Pointer register with bank selection. It holds the stored pointer and
// the registered zero flag of the last increment, and applies one
// operation per clock. Assumes mode_i is quasi-static and reset is
// synchronous, active low.
module fsel_ptr_unit
    import fsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bank_ld,
    input  logic [BANK_W-1:0] bank_lit,
    input  logic              inc_en,
    output logic [DATA_W-1:0] ptr_o,
    output logic              inc_zero_o
);

    localparam int STD_LSB  = DATA_W - BANK_W;
    localparam int WIDE_LSB = DATA_W - 1 - BANK_W;

    fsel_mode_e        mode;
    fsel_op_e          op;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] view;
    logic [DATA_W-1:0] bank_val;
    logic [DATA_W-1:0] inc_val;
    logic              inc_zero;
    logic [DATA_W-1:0] ptr_d;
    logic              zero_q;

    // Decode the raw mode code into the shared type.
    always_comb mode = fsel_mode_e'(mode_i);

    fsel_op_arbiter u_arb (
        .wr_en   (wr_en),
        .bank_ld (bank_ld),
        .inc_en  (inc_en),
        .op_o    (op)
    );

    fsel_view_mask #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_view (
        .stored_i (ptr_q),
        .mode_i   (mode),
        .view_o   (view)
    );

    fsel_bank_merge #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
        .cur_i    (ptr_q),
        .lit_i    (bank_lit),
        .mode_i   (mode),
        .merged_o (bank_val)
    );

    fsel_incr #(.DATA_W(DATA_W)) u_inc (
        .val_i  (view),
        .sum_o  (inc_val),
        .zero_o (inc_zero)
    );

    // Next stored value for the chosen operation.
    always_comb begin
        unique case (op)
            OP_WRITE: ptr_d = wr_data;
            OP_BANK:  ptr_d = bank_val;
            OP_INC:   ptr_d = inc_val;
            default:  ptr_d = ptr_q;
        endcase
    end

    // Pointer storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    // Zero flag: set only by an increment that wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_q <= 1'b0;
        else
            zero_q <= (op == OP_INC) && inc_zero;
    end

    assign ptr_o      = view;
    assign inc_zero_o = zero_q;

    // R3: standard/spare bank load fills the top bits and keeps the rest.
    p_bank_std_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 1'b0 && bank_ld && mode != MODE_WIDE) |=>
        (ptr_q[STD_LSB +: BANK_W] == $past(bank_lit)) &&
        (ptr_q[STD_LSB-1:0] == $past(ptr_q[STD_LSB-1:0])));

    // R3: a bank load leaves the zero flag low.
    p_bank_noflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ld && !wr_en) |=> !inc_zero_o);

    // R6: wide bank load keeps the group bit and the low bits.
    p_bank_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && bank_ld && mode == MODE_WIDE) |=>
        (ptr_q[DATA_W-1] == $past(ptr_q[DATA_W-1])) &&
        (ptr_q[WIDE_LSB +: BANK_W] == $past(bank_lit)) &&
        (ptr_q[WIDE_LSB-1:0] == $past(ptr_q[WIDE_LSB-1:0])));

    // R4: compatible mode always shows ones in the bank bits.
    p_compat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPAT) |-> (&ptr_o[STD_LSB +: BANK_W]));

    // R8: a byte write always lands in full.
    p_write_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q == $past(wr_data)));

    // R9: the zero flag only follows a lone increment.
    p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_zero_o |-> $past(inc_en && !wr_en && !bank_ld));

    // R5: compatible increment from all ones reports zero.
    p_compat_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !wr_en && !bank_ld && mode == MODE_COMPAT && (&ptr_o))
        |=> inc_zero_o);

endmodule

// File: tb/fsel_ptr_unit_tb_top.sv
// Bench fsel_ptr_unit_tb_top
// Scoreboard bench. A driver task applies one operation per cycle and
// pushes the expected outputs. A monitor pops each item and compares it
// with the outputs on the falling edge after the capturing edge.
module fsel_ptr_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_i;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       bank_ld;
    logic [2:0] bank_lit;
    logic       inc_en;
    logic [7:0] ptr_o;
    logic       inc_zero_o;

    typedef struct {
        logic [7:0] ptr;
        logic       z;
        string      rq;
    } exp_t;

    exp_t       sb_q[$];
    int         n_chk  = 0;
    int         n_fail = 0;
    logic [7:0] m_st   = 8'h00;

    // 250 MHz clock.
    always #2 clk = ~clk;

    fsel_ptr_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .bank_ld    (bank_ld),
        .bank_lit   (bank_lit),
        .inc_en     (inc_en),
        .ptr_o      (ptr_o),
        .inc_zero_o (inc_zero_o)
    );

    // Visible value from the requirements: mode 1 shows ones in bits 7:5.
    function automatic logic [7:0] vis(input logic [7:0] s, input logic [1:0] md);
        return (md == 2'd1) ? (s | 8'hE0) : s;
    endfunction

    task automatic check(input string rq, input logic [7:0] act_p, input logic [7:0] exp_p,
                         input logic act_z, input logic exp_z);
        n_chk++;
        if (act_p !== exp_p || act_z !== exp_z) begin
            n_fail++;
            $display("FAIL %s: ptr=%h z=%b expected ptr=%h z=%b", rq, act_p, act_z, exp_p, exp_z);
        end
    endtask

    // Driver: apply one operation, update the model, push the expectation.
    task automatic op(input logic [1:0] md, input logic w, input logic [7:0] d,
                      input logic b, input logic [2:0] l, input logic i, input string rq);
        logic       z;
        logic [7:0] s;
        @(negedge clk); #1;
        mode_i = md; wr_en = w; wr_data = d; bank_ld = b; bank_lit = l; inc_en = i;
        z = 1'b0;
        if (w)
            m_st = d;
        else if (b) begin
            if (md == 2'd2) m_st[6:4] = l;
            else            m_st[7:5] = l;
        end else if (i) begin
            s = vis(m_st, md) + 8'd1;
            m_st = s;
            z = (s == 8'h00);
        end
        @(posedge clk); #1;
        sb_q.push_back('{vis(m_st, md), z, rq});
        wr_en = 1'b0; bank_ld = 1'b0; inc_en = 1'b0;
    endtask

    // Monitor: compare each result on the falling edge after its capture.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.rq, ptr_o, e.ptr, inc_zero_o, e.z);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: ptr=%h z=%b expected completion", ptr_o, inc_zero_o);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_i = 2'd0; wr_en = 1'b0; wr_data = 8'h00;
        bank_ld = 1'b0; bank_lit = 3'd0; inc_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset std", ptr_o, 8'h00, inc_zero_o, 1'b0);
        #1 mode_i = 2'd1;
        @(negedge clk);
        check("R1 reset compat", ptr_o, 8'hE0, inc_zero_o, 1'b0);
        #1 mode_i = 2'd2;
        @(negedge clk);
        check("R1 reset wide", ptr_o, 8'h00, inc_zero_o, 1'b0);
        #1 mode_i = 2'd0;
        @(posedge clk); #1 rst_n = 1'b1;

        // Standard layout.
        op(2'd0, 1, 8'h1A, 0, 3'd0, 0, "R2 byte write");
        op(2'd0, 0, 8'h00, 1, 3'd5, 0, "R3 std bank load");
        op(2'd0, 0, 8'h00, 0, 3'd0, 1, "R9 increment");
        op(2'd0, 1, 8'hFF, 0, 3'd0, 0, "R2 write ones");
        op(2'd0, 0, 8'h00, 0, 3'd0, 1, "R9 wrap to zero");
        op(2'd0, 0, 8'h00, 0, 3'd0, 0, "R9 flag drops");
        op(2'd0, 1, 8'h33, 1, 3'd7, 0, "R8 write over bank");
        op(2'd0, 0, 8'h00, 1, 3'd2, 1, "R8 bank over inc");
        op(2'd0, 1, 8'hFF, 0, 3'd0, 0, "R2 write ones again");
        op(2'd0, 0, 8'h00, 1, 3'd0, 0, "R3 bank zero keeps low");

        // Compatible layout: the read mask acts on the stored value.
        op(2'd1, 0, 8'h00, 0, 3'd0, 0, "R4 mask on stored");
        op(2'd1, 1, 8'h05, 0, 3'd0, 0, "R4 write keeps high");
        op(2'd1, 0, 8'h00, 1, 3'd0, 0, "R4 bank load ignored");
        op(2'd1, 1, 8'h1F, 0, 3'd0, 0, "R4 all ones visible");
        op(2'd1, 0, 8'h00, 0, 3'd0, 1, "R5 compat wrap");
        op(2'd1, 0, 8'h00, 0, 3'd0, 1, "R5 next increment");

        // Wide layout.
        op(2'd2, 0, 8'h00, 1, 3'd3, 0, "R6 wide bank group kept");
        op(2'd2, 1, 8'hD7, 0, 3'd0, 0, "R7 wide full write");
        op(2'd2, 0, 8'h00, 1, 3'd0, 0, "R6 wide bank bit7 held");
        op(2'd2, 1, 8'h27, 0, 3'd0, 0, "R7 wide write low group");
        op(2'd2, 0, 8'h00, 1, 3'd7, 0, "R6 wide bank low group");
        op(2'd2, 0, 8'h00, 0, 3'd0, 1, "R9 wide increment");

        // Spare mode code.
        op(2'd3, 1, 8'h00, 0, 3'd0, 0, "R10 spare write");
        op(2'd3, 0, 8'h00, 1, 3'd6, 0, "R10 spare as standard");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule